// File: doc/BRIEF.md
# Serial Register Port with Frame-Length Check

This block is the slave end of a four-wire serial link, and it gives a host access to a bank of on-chip registers. Each time the chip select is held low, the host sends one 24-bit command. The first bit is a read/write flag, the next seven bits are a register address and the last sixteen bits are write data. Nothing is committed while the frame is still open. The block acts on the command only after chip select returns high. A write then goes out as one strobe on the internal register port. A read also gets one strobe, and the data that comes back is held until the next frame.

The serial output is one frame behind the input. While the host clocks in a command, the block shifts out a 24-bit response. The response starts with a status byte, followed by the data of the previous read. The status byte also reports whether the previous frame carried exactly 24 clocks. When a frame is cut short, the missing low-order bits are taken as zero. When a frame runs long, the surplus bits are dropped. In both cases the status byte of the next response has its error bit set.

All serial inputs pass through synchronisers into the system clock domain and are oversampled there. The serial clock must therefore run well below the system clock.

A controller with four states sequences each frame:
- `ST_IDLE`: waits while chip select is high.
- **open**: `ST_IDLE` → `ST_SHIFT` when chip select is seen low. This also loads the response and clears the receive word and the counter.
- `ST_SHIFT`: counts rising serial-clock edges and shifts.
- **close**: `ST_SHIFT` → `ST_COMMIT` when chip select is seen high.
- `ST_COMMIT`: records the frame-length verdict and issues the strobe.
- **fetch**: `ST_COMMIT` → `ST_FETCH` for a read.
- **done**: `ST_COMMIT` → `ST_IDLE` otherwise.
- `ST_FETCH`: captures the read data.
- **retire**: `ST_FETCH` → `ST_IDLE`.

Top module: `spi_frame_port`

## Requirements
- R1: While chip select is low, `spi_mosi` is sampled on rising `spi_sclk` edges, MSB first. Frame bit 23 set to 1 means read and 0 means write. Bits 22:16 are the register address and bits 15:0 are the write data.
- R2: A write frame produces exactly one cycle of `reg_wr_en`, with `reg_addr` and `reg_wdata` taken from the frame. The strobe comes only after chip select has returned high, never while it is low.
- R3: A read frame produces one cycle of `reg_rd_en` after chip select returns high. `reg_rdata` is taken one cycle later and appears as response bits 15:0 of the next frame. A response that follows a write frame carries 0x0000 in those bits.
- R4: Response bits 23:16 form a status byte. It is 0x05 when the previous frame had exactly 24 rising clocks, and also after reset.
- R5: If the previous frame had fewer or more than 24 rising clocks, the status byte is 0x45 (error mask 0x40).
- R6: In a short frame, the bit positions that were never clocked are taken as 0, and the command is still executed.
- R7: In a long frame, every bit after the 24th is ignored, and the first 24 bits form the command.
- R8: The error bit is reported once. It clears after a frame that was exactly 24 clocks long has carried it out. It stays set if the reporting frame was itself malformed.
- R9: `spi_miso` changes after falling `spi_sclk` edges, and its first bit is valid before the first rising edge. `spi_miso_oe` is low (pad released) whenever chip select has been high for the last three system clocks.
- R10: `spi_sclk` edges while chip select is high have no effect on the next frame, such as traffic to another device on the same bus.
- R11: A frame with no clock at all issues no strobe, but it sets the error bit.
- R12: `reg_wr_en` and `reg_rd_en` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host (idles low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid the cycle after `reg_rd_en` |

## Verification
The hardest case to reach is a malformed frame followed straight away by a second malformed frame. Only that pair shows whether the error bit is held over rather than cleared once it has been reported. The stimulus therefore chains a 20-clock write, a 28-clock read and a zero-clock frame with well-formed frames around them. It also sends a 10-clock read right after a well-formed one, and compares the status byte of each following response. Serial-clock toggles with chip select high are placed between two well-formed frames. The read address decoded after them shows whether any stray bit leaked into the frame.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_FETCH
    } fc_state_e;

    localparam logic [7:0] STATUS_BASE = 8'h05;
    localparam logic [7:0] STATUS_FERR = 8'h40;

endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter #(
    parameter int RX_W  = 24,
    parameter int TX_W  = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             mosi,
    input  logic [TX_W-1:0]  tx_word,
    output logic [RX_W-1:0]  rx_word,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             miso_bit
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RX_W + 1);

    logic [TX_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
            bit_cnt <= '0;
            tx_q    <= '0;
        end else if (start) begin
            rx_word <= '0;
            bit_cnt <= '0;
            tx_q    <= tx_word;
        end else if (active) begin
            if (sclk_rise) begin
                for (int b = 0; b < RX_W; b++) begin
                    if (bit_cnt == CNT_W'(RX_W - 1 - b)) rx_word[b] <= mosi;
                end
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall) tx_q <= {tx_q[TX_W-2:0], 1'b0};
        end
    end

    assign miso_bit = tx_q[TX_W-1];

endmodule

// File: rtl/spi_fc_ctrl.sv
module spi_fc_ctrl
    import spi_fc_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int RX_W   = 24,
    parameter int TX_W   = 24,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic [RX_W-1:0]   rx_word,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              start,
    output logic              active,
    output logic [TX_W-1:0]   tx_word,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    fc_state_e         state_q, state_d;
    logic              ferr_q;
    logic [DATA_W-1:0] rsp_q;
    logic              is_read;
    logic              has_clk;

    assign is_read = rx_word[RX_W-1];
    assign has_clk = (bit_cnt != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_n_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_n_s)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = (has_clk && is_read) ? ST_FETCH : ST_IDLE;
            ST_FETCH:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // frame verdict and held response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            rsp_q  <= '0;
        end else if (state_q == ST_COMMIT) begin
            ferr_q <= (bit_cnt != CNT_W'(RX_W));
            if (has_clk && !is_read) rsp_q <= '0;
        end else if (state_q == ST_FETCH) begin
            rsp_q <= reg_rdata;
        end
    end

    // outputs
    always_comb begin
        start  = 1'b0;
        active = 1'b0;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   start  = !cs_n_s;
            ST_SHIFT:  active = 1'b1;
            ST_COMMIT: begin
                wr_en = has_clk && !is_read;
                rd_en = has_clk && is_read;
            end
            ST_FETCH:  ;
            default:   ;
        endcase
    end

    assign addr    = rx_word[RX_W-2 -: ADDR_W];
    assign wdata   = rx_word[DATA_W-1:0];
    assign tx_word = {STATUS_BASE | (ferr_q ? STATUS_FERR : 8'h00), rsp_q};

endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int RX_W  = 1 + ADDR_W + DATA_W;
    localparam int TX_W  = 8 + DATA_W;
    localparam int CNT_W = $clog2(RX_W + 2);

    logic [2:0]       pins_s;
    logic             cs_n_s, sclk_s, mosi_s, sclk_d;
    logic             start, active;
    logic [TX_W-1:0]  tx_word;
    logic [RX_W-1:0]  rx_word;
    logic [CNT_W-1:0] bit_cnt;

    spi_fc_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout  (pins_s)
    );

    assign {cs_n_s, sclk_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    spi_fc_shifter #(
        .RX_W  (RX_W),
        .TX_W  (TX_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .sclk_rise (sclk_s & ~sclk_d),
        .sclk_fall (~sclk_s & sclk_d),
        .mosi      (mosi_s),
        .tx_word   (tx_word),
        .rx_word   (rx_word),
        .bit_cnt   (bit_cnt),
        .miso_bit  (spi_miso)
    );

    spi_fc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RX_W   (RX_W),
        .TX_W   (TX_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .rx_word   (rx_word),
        .bit_cnt   (bit_cnt),
        .reg_rdata (reg_rdata),
        .start     (start),
        .active    (active),
        .tx_word   (tx_word),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata)
    );

    assign spi_miso_oe = active;

endmodule

// File: rtl/spi_frame_port_chk.sv
module spi_frame_port_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso_oe,
    input logic reg_wr_en,
    input logic reg_rd_en
);

    localparam int LAT = SYNC_STAGES + 1;

    // R9: pad driven only when chip select was low LAT cycles earlier
    p_oe_follows_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !$past(spi_cs_n, LAT));

    // R2: strobes only once chip select has gone high again
    p_strobe_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> $past(spi_cs_n, LAT));

    // R12: never both strobes at once
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R12: each strobe lasts a single cycle
    p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |=> !(reg_wr_en || reg_rd_en));

endmodule

bind spi_frame_port spi_frame_port_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en)
);

// File: tb/sim_spi_frame_port.sv
module sim_spi_frame_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe, reg_wr_en, reg_rd_en;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = 16'h0;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    // external register file behind the port
    logic [15:0] dev_mem [128];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) dev_mem[i] <= 16'hA000 ^ 16'(i * 37);
        end else begin
            if (reg_wr_en) dev_mem[reg_addr] <= reg_wdata;
            if (reg_rd_en) reg_rdata <= dev_mem[reg_addr];
        end
    end

    // reference model
    typedef struct {
        bit          rd;
        logic [6:0]  a;
        logic [15:0] d;
    } ev_t;

    ev_t         exp_q[$];
    logic [15:0] ref_mem [128];
    bit          m_err = 1'b0;
    logic [15:0] m_rsp = 16'h0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en || reg_rd_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3/R11 unexpected strobe", {15'h0, reg_rd_en, 9'h0, reg_addr}, 32'h0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(reg_rd_en == e.rd && reg_wr_en == !e.rd, "R12 strobe kind",
                        {30'h0, reg_rd_en, reg_wr_en}, {30'h0, e.rd, !e.rd});
                    chk(reg_addr == e.a, "R1 strobe address", {25'h0, reg_addr}, {25'h0, e.a});
                    if (!e.rd) chk(reg_wdata == e.d, "R2/R6 write data", {16'h0, reg_wdata}, {16'h0, e.d});
                end
            end
            if (hi_cnt >= 3) chk(!spi_miso_oe, "R9 pad released", {31'h0, spi_miso_oe}, 32'h0);
            if (spi_cs_n) hi_cnt++;
            else          hi_cnt = 0;
        end
    end

    task automatic frame(input logic [23:0] word, input int nclk, input string req);
        logic [23:0] got, expv, mask, eff;
        int n24;
        got  = '0;
        expv = {8'h05 | (m_err ? 8'h40 : 8'h00), m_rsp};
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            spi_mosi = (i < 24) ? word[23-i] : 1'b1;
            repeat (HALF/2) @(negedge clk);
            if (i < 24) got[23-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (HALF/2) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        n24  = (nclk > 24) ? 24 : nclk;
        mask = (n24 == 0) ? 24'h0 : (~24'h0 << (24 - n24));
        if (nclk > 0) chk((got & mask) == (expv & mask), req, {8'h0, got & mask}, {8'h0, expv & mask});
        m_err = (nclk != 24);
        if (nclk > 0) begin
            eff = word & mask;
            if (eff[23]) begin
                m_rsp = ref_mem[eff[22:16]];
                exp_q.push_back('{1'b1, eff[22:16], 16'h0});
            end else begin
                ref_mem[eff[22:16]] = eff[15:0];
                m_rsp = 16'h0;
                exp_q.push_back('{1'b0, eff[22:16], eff[15:0]});
            end
        end
        repeat (16) @(negedge clk);
        chk(exp_q.size() == 0, {req, " strobe issued"}, exp_q.size(), 0);
    endtask

    function automatic logic [23:0] rd(input logic [6:0] a);
        return {1'b1, a, 16'h0};
    endfunction

    function automatic logic [23:0] wr(input logic [6:0] a, input logic [15:0] d);
        return {1'b0, a, d};
    endfunction

    initial begin
        for (int i = 0; i < 128; i++) ref_mem[i] = 16'hA000 ^ 16'(i * 37);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_miso_oe && !reg_wr_en && !reg_rd_en, "R9 reset state",
            {29'h0, spi_miso_oe, reg_wr_en, reg_rd_en}, 32'h0);

        frame(wr(7'h12, 16'hBEEF), 24, "R4 reset status and R2 write");
        frame(rd(7'h12), 24, "R3 response after write");
        frame(rd(7'h05), 24, "R3 read data next frame");
        frame(wr(7'h20, 16'h1234), 20, "R6 short write");
        frame(rd(7'h20), 24, "R5/R6 error status after short frame");
        frame(rd(7'h05), 28, "R7 long read");
        frame(wr(7'h30, 16'h5A5A), 24, "R5/R8 error after long frame");
        frame(rd(7'h30), 24, "R8 flag cleared");
        frame(24'h0, 0, "R11 empty frame");
        frame(rd(7'h7F), 24, "R11 error after empty frame");

        // stray clocks with chip select high
        spi_mosi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            repeat (HALF) @(negedge clk) spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk) spi_sclk = 1'b0;
        end
        spi_mosi = 1'b0;
        frame(rd(7'h12), 24, "R10 stray clocks ignored");

        frame(rd(7'h30), 10, "R6 short read");
        frame(rd(7'h05), 3, "R8 second bad frame keeps flag");
        frame(wr(7'h41, 16'h0F0F), 24, "R8 flag held after bad report");
        frame(rd(7'h41), 24, "R4/R8 clean again");
        frame(rd(7'h00), 24, "R1/R3 read back");
        frame(wr(7'h7F, 16'hFFFF), 30, "R7 long write");
        frame(rd(7'h7F), 24, "R5/R7 long write result");
        frame(rd(7'h7F), 24, "R3 read of long write");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule